// File: doc/BRIEF.md
# Heterodyne Beat Demodulator with Decimating Filter

This block turns a fast stream of digitized heterodyne beat samples into a slow control word for a laser-steering DAC. Each accepted 15-bit signed sample is multiplied by a locally generated oscillator. That oscillator runs at an offset frequency chosen by the user, which is the frequency the beat note should be held at. The product then goes through a three-stage integrate/comb decimator that keeps one value in forty. A first-order recursive smoother with a programmable shift follows, and last comes a saturating scaler to 16 bits.

At the nominal 40 MHz sample rate the output updates at 1 MHz. The beat note has to stay below half the sample rate (20 MHz). The oscillator frequency is set by a 32-bit tuning word. That word is captured only at the boundary between output blocks, so a block is never demodulated with two different frequencies.

Top module: `hetero_demod`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and out_data_o is 0. Reset clears the oscillator phase, the active tuning word, the sample count and all filter state, so the first block after reset is demodulated with an oscillator that outputs 0.
- R2: The oscillator value for a sample is formed from the 12 most significant bits p of the 32-bit phase that was current before that sample. With h = p[11] and x = p[10:0], let m = min((x*(2048-x)) >> 9, 2047). The value is -m when h is 1 and +m otherwise. After each accepted sample the phase grows by the active tuning word, modulo 2^32.
- R3: The mixer product is the exact 27-bit signed product of in_data_i and the oscillator value. Cycles with in_valid_i low are ignored, whatever in_data_i holds: they do not advance the phase, the sample count or any filter.
- R4: out_valid_o is a one-cycle pulse after every 40th accepted sample. It is high during the cycle that follows the fourth clock edge after the edge that accepts that 40th sample.
- R5: The decimator has three cascaded integrators that each add their input on every accepted sample, in 45-bit two's-complement wrap-around arithmetic. On each 40th sample, the final integrator value passes through three cascaded first-difference stages. The result, arithmetically shifted right by 16, is the 29-bit decimator output x.
- R6: The smoother updates once per output block as y <= y + ((x - y) >>> k), where k = iir_shift_i is sampled three edges after the accepting edge. With k = 0, y equals x.
- R7: out_data_o is y arithmetically shifted right by 8, clamped to the range -32768..32767 rather than wrapped.
- R8: ftw_i is captured into the active tuning word only on the edge that accepts the 40th sample of a block. That phase step still uses the previous word. Changes of ftw_i at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | 15 | Signed beat sample |
| ftw_i | input | 32 | Oscillator tuning word, phase step per sample |
| iir_shift_i | input | 4 | Smoother shift k |
| out_valid_o | output | 1 | Control word strobe, once per 40 samples |
| out_data_o | output | 16 | Signed saturated control word |

## Verification
Two things can fall on the same clock edge: loading a new tuning word and advancing the phase with the old word on the last sample of a block. In one phase of the bench, ftw_i changes on every cycle, so it also changes on boundary cycles and in the middle of blocks. A bit-exact reference model, which captures the word only at the block's final sample, then has to agree with every control word that follows. In the same way, an output pulse lands on cycles where new samples are being accepted, and each pulse is checked for both its cycle position and its value.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int unsigned HD_IN_W  = 15;
  localparam int unsigned HD_OUT_W = 16;
  localparam int unsigned HD_PH_W  = 32;
  localparam int unsigned HD_LO_W  = 12;
  localparam int unsigned HD_DEC   = 40;

  // bit growth of an N-stage integrate/comb decimator with ratio r
  function automatic int unsigned cic_growth(int unsigned r, int unsigned n);
    return n * $clog2(r);
  endfunction
endpackage

// File: rtl/hd_nco_mix.sv
module hd_nco_mix #(
  parameter int unsigned IN_W = 15,
  parameter int unsigned PH_W = 32,
  parameter int unsigned LO_W = 12,
  parameter int unsigned DEC  = 40
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic signed [IN_W-1:0]        in_data_i,
  input  logic [PH_W-1:0]               ftw_i,
  output logic signed [IN_W+LO_W-1:0]   prod_o,
  output logic                          prod_valid_o,
  output logic                          prod_last_o,
  output logic [PH_W-1:0]               ftw_act_o
);
  localparam int unsigned A      = LO_W - 1;
  localparam int unsigned PROD_W = IN_W + LO_W;
  localparam int unsigned CNT_W  = $clog2(DEC);

  logic [PH_W-1:0]        phase_q, ftw_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [LO_W-1:0]        idx;
  logic [A-1:0]           frac, mag;
  logic [2*A-1:0]         sq, mag_w;
  logic signed [LO_W-1:0] lo;
  logic                   last;

  // parabolic sine: 4x(1-x) over each half period
  always_comb begin
    idx   = phase_q[PH_W-1 -: LO_W];
    frac  = idx[A-1:0];
    sq    = {{A{1'b0}}, frac} * ({{(A-1){1'b0}}, 1'b1, {A{1'b0}}} - {{A{1'b0}}, frac});
    mag_w = sq >> (A - 2);
    mag   = (|mag_w[2*A-1:A]) ? {A{1'b1}} : mag_w[A-1:0];
    lo    = idx[LO_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  assign last = (cnt_q == CNT_W'(DEC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= '0;
      ftw_q        <= '0;
      cnt_q        <= '0;
      prod_o       <= '0;
      prod_valid_o <= 1'b0;
      prod_last_o  <= 1'b0;
    end else begin
      prod_valid_o <= in_valid_i;
      prod_last_o  <= in_valid_i && last;
      if (in_valid_i) begin
        prod_o  <= {{(PROD_W-IN_W){in_data_i[IN_W-1]}}, in_data_i} *
                   {{(PROD_W-LO_W){lo[LO_W-1]}}, lo};
        phase_q <= phase_q + ftw_q;
        if (last) begin
          cnt_q <= '0;
          ftw_q <= ftw_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ftw_act_o = ftw_q;
endmodule

// File: rtl/hd_cic.sv
module hd_cic #(
  parameter int unsigned IN_W   = 27,
  parameter int unsigned STAGES = 3,
  parameter int unsigned ACC_W  = 45,
  parameter int unsigned SHIFT  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          last_i,
  input  logic signed [IN_W-1:0]        x_i,
  output logic                          valid_o,
  output logic signed [ACC_W-SHIFT-1:0] y_o
);
  localparam int unsigned OUT_W = ACC_W - SHIFT;

  logic signed [ACC_W-1:0] integ_q [STAGES];
  logic signed [ACC_W-1:0] integ_n [STAGES];
  logic signed [ACC_W-1:0] dly_q   [STAGES];
  logic signed [ACC_W-1:0] comb_n  [STAGES];
  logic signed [ACC_W-1:0] dec_q;
  logic                    dec_v_q;

  always_comb begin
    integ_n[0] = integ_q[0] + {{(ACC_W-IN_W){x_i[IN_W-1]}}, x_i};
    for (int s = 1; s < STAGES; s++) integ_n[s] = integ_q[s] + integ_n[s-1];
    comb_n[0] = dec_q - dly_q[0];
    for (int s = 1; s < STAGES; s++) comb_n[s] = comb_n[s-1] - dly_q[s];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        integ_q[s] <= '0;
        dly_q[s]   <= '0;
      end else begin
        if (valid_i) integ_q[s] <= integ_n[s];
        if (dec_v_q) dly_q[s] <= (s == 0) ? dec_q : comb_n[(s == 0) ? 0 : s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q   <= '0;
      dec_v_q <= 1'b0;
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      dec_v_q <= valid_i && last_i;
      if (valid_i && last_i) dec_q <= integ_n[STAGES-1];
      valid_o <= dec_v_q;
      if (dec_v_q) y_o <= OUT_W'(comb_n[STAGES-1] >>> SHIFT);
    end
  end
endmodule

// File: rtl/hd_iir_sat.sv
module hd_iir_sat #(
  parameter int unsigned W         = 29,
  parameter int unsigned SH_W      = 4,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned OUT_SHIFT = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [W-1:0]     x_i,
  input  logic [SH_W-1:0]         shift_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] data_o
);
  localparam logic signed [W-1:0] HI = {{(W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [W-1:0] LO = {{(W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [W-1:0] y_q, z;
  logic signed [W:0]   diff, step, sum;
  logic                v_q;

  always_comb begin
    diff = {x_i[W-1], x_i} - {y_q[W-1], y_q};
    step = diff >>> shift_i;
    sum  = {y_q[W-1], y_q} + step;
    z    = y_q >>> OUT_SHIFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= '0;
      v_q     <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      v_q     <= valid_i;
      valid_o <= v_q;
      if (valid_i) y_q <= sum[W-1:0];
      if (v_q) begin
        if (z > HI)      data_o <= {1'b0, {(OUT_W-1){1'b1}}};
        else if (z < LO) data_o <= {1'b1, {(OUT_W-1){1'b0}}};
        else             data_o <= z[OUT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/hetero_demod.sv
module hetero_demod
  import hd_pkg::*;
#(
  parameter int unsigned IN_W      = HD_IN_W,
  parameter int unsigned OUT_W     = HD_OUT_W,
  parameter int unsigned PH_W      = HD_PH_W,
  parameter int unsigned LO_W      = HD_LO_W,
  parameter int unsigned DEC       = HD_DEC,
  parameter int unsigned STAGES    = 3,
  parameter int unsigned CIC_SHIFT = 16,
  parameter int unsigned SH_W      = 4,
  parameter int unsigned OUT_SHIFT = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  in_data_i,
  input  logic [PH_W-1:0]         ftw_i,
  input  logic [SH_W-1:0]         iir_shift_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o
);
  localparam int unsigned PROD_W = IN_W + LO_W;
  localparam int unsigned ACC_W  = PROD_W + cic_growth(DEC, STAGES);
  localparam int unsigned CIC_W  = ACC_W - CIC_SHIFT;

  logic signed [PROD_W-1:0] prod;
  logic                     prod_v, prod_last, cic_v;
  logic signed [CIC_W-1:0]  cic_y;
  logic [PH_W-1:0]          ftw_act;

  hd_nco_mix #(.IN_W(IN_W), .PH_W(PH_W), .LO_W(LO_W), .DEC(DEC)) i_nco (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .ftw_i,
    .prod_o(prod), .prod_valid_o(prod_v), .prod_last_o(prod_last), .ftw_act_o(ftw_act)
  );

  hd_cic #(.IN_W(PROD_W), .STAGES(STAGES), .ACC_W(ACC_W), .SHIFT(CIC_SHIFT)) i_cic (
    .clk_i, .rst_ni, .valid_i(prod_v), .last_i(prod_last), .x_i(prod),
    .valid_o(cic_v), .y_o(cic_y)
  );

  hd_iir_sat #(.W(CIC_W), .SH_W(SH_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) i_iir (
    .clk_i, .rst_ni, .valid_i(cic_v), .x_i(cic_y), .shift_i(iir_shift_i),
    .valid_o(out_valid_o), .data_o(out_data_o)
  );
endmodule

// File: rtl/hd_checker.sv
module hd_checker #(
  parameter int unsigned DEC  = 40,
  parameter int unsigned PH_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [PH_W-1:0] ftw_act_i,
  input logic            out_valid_i
);
  localparam int unsigned CW = $clog2(DEC);

  logic [CW-1:0] n_q;
  logic [4:0]    sr_q;
  logic          acc_last;

  assign acc_last = in_valid_i && (n_q == CW'(DEC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q  <= '0;
      sr_q <= '0;
    end else begin
      if (in_valid_i) n_q <= acc_last ? '0 : n_q + 1'b1;
      sr_q <= {sr_q[3:0], acc_last};
    end
  end

  // R4: pulse lands exactly four edges after the accepting edge
  a_r4_out_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i == sr_q[4]);
  // R4: single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |=> !out_valid_i);
  // R8: active word moves only at a block boundary
  a_r8_ftw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_last |=> $stable(ftw_act_i));
  // R3: idle cycles leave the active word untouched
  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(ftw_act_i));
endmodule

bind hetero_demod hd_checker #(.DEC(DEC), .PH_W(PH_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .ftw_act_i(ftw_act), .out_valid_i(out_valid_o)
);

// File: tb/test_hetero_demod.sv
module test_hetero_demod;
  localparam int CLK_PERIOD = 10;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               in_valid_i = 1'b0;
  logic signed [14:0] in_data_i = '0;
  logic [31:0]        ftw_i = '0;
  logic [3:0]         iir_shift_i = 4'd4;
  logic               out_valid_o;
  logic signed [15:0] out_data_o;

  hetero_demod i_hetero_demod (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  string cur_req = "R2";
  logic signed [15:0] last_out = '0;

  // reference model state
  logic [31:0]        m_ph, m_ftw;
  int                 m_cnt;
  logic signed [44:0] m_i [3];
  logic signed [44:0] m_d [3];
  logic signed [28:0] m_y;
  int                 k_b = 4;
  int                 q_edge[$];
  logic signed [15:0] q_val[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int lo_f(logic [31:0] ph);
    int x, m;
    x = int'(ph[30:20]);
    m = (x * (2048 - x)) >>> 9;
    if (m > 2047) m = 2047;
    return ph[31] ? -m : m;
  endfunction

  function automatic logic signed [15:0] sat_f(logic signed [28:0] y);
    longint v;
    v = longint'(y) >>> 8;
    if (v > 32767) return 16'sh7fff;
    if (v < -32768) return 16'sh8000;
    return 16'(v);
  endfunction

  task automatic model_reset();
    m_ph = '0; m_ftw = '0; m_cnt = 0; m_y = '0;
    for (int s = 0; s < 3; s++) begin m_i[s] = '0; m_d[s] = '0; end
    q_edge.delete(); q_val.delete();
  endtask

  task automatic model_accept(logic signed [14:0] d, logic [31:0] f, int edge_n);
    longint p, diff, step;
    logic signed [44:0] x, c0, c1, c2;
    logic signed [28:0] cx;
    p = longint'(d) * longint'(lo_f(m_ph));
    m_i[0] = m_i[0] + 45'(p);
    m_i[1] = m_i[1] + m_i[0];
    m_i[2] = m_i[2] + m_i[1];
    m_ph = m_ph + m_ftw;
    m_cnt++;
    if (m_cnt == 40) begin
      m_cnt = 0;
      m_ftw = f;
      x = m_i[2];
      c0 = x - m_d[0]; c1 = c0 - m_d[1]; c2 = c1 - m_d[2];
      m_d[0] = x; m_d[1] = c0; m_d[2] = c1;
      cx = 29'(c2 >>> 16);
      diff = longint'(cx) - longint'(m_y);
      step = diff >>> k_b;
      m_y = 29'(longint'(m_y) + step);
      q_edge.push_back(edge_n + 4);
      q_val.push_back(sat_f(m_y));
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (q_edge.size() > 0 && q_edge[0] < cyc) begin
        check(1'b0, "R4", "missing pulse at edge", 0, q_edge[0]);
        void'(q_edge.pop_front()); void'(q_val.pop_front());
      end
      if (out_valid_o) begin
        if (q_edge.size() == 0) begin
          check(1'b0, "R4", "unexpected pulse at edge", cyc, -1);
        end else begin
          check(q_edge[0] == cyc, "R4", "pulse edge", cyc, q_edge[0]);
          check(out_data_o == q_val[0], cur_req, "control word", out_data_o, q_val[0]);
          void'(q_edge.pop_front()); void'(q_val.pop_front());
        end
        last_out = out_data_o;
      end
    end
  end

  task automatic drive(bit v, logic signed [14:0] d, logic [31:0] f);
    @(negedge clk_i);
    in_valid_i = v; in_data_i = d; ftw_i = f;
    if (v) model_accept(d, f, cyc + 1);
  endtask

  // dmode 0 random, 1 follow oscillator sign, 2 oppose it; fmode 1 random word each cycle
  task automatic feed(int nacc, int vprob, int dmode, int fmode, logic [31:0] f);
    int got = 0;
    while (got < nacc) begin
      bit v;
      logic signed [14:0] d;
      logic [31:0] fw;
      v = ($urandom_range(99) < vprob);
      fw = fmode ? $urandom : f;
      d = 15'($urandom);
      if (dmode == 1) d = (lo_f(m_ph) >= 0) ? 15'sd16383 : -15'sd16384;
      if (dmode == 2) d = (lo_f(m_ph) >= 0) ? -15'sd16384 : 15'sd16383;
      drive(v, d, fw);
      if (v) got++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 15'($urandom), ftw_i);
  endtask

  task automatic set_k(int k);
    idle(8);
    k_b = k; iir_shift_i = 4'(k);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "R4", "watchdog expired", cyc, 200000);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] f0;
    void'($urandom(32'd91173));
    model_reset();
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1", "valid in reset", out_valid_o, 0);
    check(out_data_o == 16'sd0, "R1", "data in reset", out_data_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 oscillator with steady word
    cur_req = "R2"; f0 = 32'h0333_3333;
    feed(240, 100, 0, 0, f0);
    idle(8);
    // R5 decimator math with a different word
    cur_req = "R5";
    feed(200, 100, 0, 0, 32'h1b00_0421);
    idle(8);
    // R3 gaps with junk on in_data_i
    cur_req = "R3";
    feed(160, 45, 0, 0, 32'h0a3d_70a4);
    idle(8);
    // R8 word changes every cycle, boundary cycles included
    cur_req = "R8";
    feed(200, 80, 0, 1, 32'h0);
    // R6 pass-through and heavy smoothing
    set_k(0); cur_req = "R6";
    feed(120, 100, 0, 0, 32'h2222_2222);
    set_k(15);
    feed(120, 90, 0, 0, 32'h0700_0000);
    // R7 saturation both ways
    set_k(0); cur_req = "R7";
    feed(40, 100, 0, 0, 32'h0800_0000);
    feed(160, 100, 1, 0, 32'h0800_0000);
    idle(8);
    check(last_out == 16'sh7fff, "R7", "positive clamp", last_out, 32767);
    feed(160, 100, 2, 0, 32'h0800_0000);
    idle(8);
    check(last_out == 16'sh8000, "R7", "negative clamp", last_out, -32768);

    // R1 reset mid-block
    set_k(3);
    feed(20, 100, 0, 0, 32'h0123_4567);
    @(negedge clk_i);
    in_valid_i = 1'b0; rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1", "valid after mid reset", out_valid_o, 0);
    check(out_data_o == 16'sd0, "R1", "data after mid reset", out_data_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cur_req = "R1";
    feed(120, 100, 0, 0, 32'h0555_5555);
    idle(10);
    check(q_edge.size() == 0, "R4", "pending pulses at end", q_edge.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule